// File: doc/BRIEF.md
# Paravirtual Device Register Front-End

This block is the control register file that a driver uses to bring up a paravirtual I/O device. It sits on a simple 32-bit register bus made of an address, a write strobe, write data and combinational read data. The block answers identification reads. It negotiates a 64-bit feature set one 32-bit word at a time, and it holds the configuration of every virtual queue behind a single queue-select register. It also keeps an interrupt status mask that is cleared by acknowledge writes, and a device status byte. Writing zero to the status byte resets the device.

The device core sees the outcome as plain signals: the queue ready bits, queue sizes and the three 64-bit ring area addresses of each queue, the negotiated driver features, the status byte, a one-cycle reset pulse and one interrupt line. The core raises interrupt events on a two-bit input. No part of this interface streams data, so none of it carries a valid/ready handshake. Every bus access completes in the cycle it is presented and cannot be back-pressured: a write takes effect at the next clock edge, and read data follows the address in the same cycle.

Top module: `pvd_regfile`

## Requirements
- R1: Reads of 0x000 return 0x74726976, 0x004 returns 2, 0x008 returns the DEVICE_ID parameter and 0x00C returns the VENDOR_ID parameter.
- R2: A read of 0x010 returns DEV_FEATURES[31:0] when the word select last written at 0x014 is 0, DEV_FEATURES[63:32] when it is 1, and zero for any other select value.
- R3: A write to 0x020 stores the data into drv_feat_o[31:0] when the select at 0x024 is 0, and into drv_feat_o[63:32] when it is 1, from the next cycle on. Any other select value makes the write have no effect.
- R4: The value written at 0x030 selects a queue, numbered from 0. A read of 0x034 returns QUEUE_MAX for a selected queue below NUM_QUEUES and zero for any other selection.
- R5: A read of 0x044 returns, in bit 0, bit 0 of the last value written to 0x044 for the selected queue. Each queue keeps its own bit, and the bit drives q_ready_o[queue].
- R6: Writes to 0x038 (size) and to the low/high address pairs at 0x080/0x084 (descriptor area), 0x090/0x094 (driver area) and 0x0A0/0x0A4 (device area) update the selected queue's outputs from the next cycle on. These writes are ignored when the selection is not below NUM_QUEUES.
- R7: The interrupt status at 0x060 sets bit 0 on event input bit 0 (used buffer) and bit 1 on event input bit 1 (configuration change). A write to 0x064 clears the status bits that are set in its data, and an event that arrives in the same cycle as the acknowledge of its bit leaves that bit set.
- R8: irq_o is high exactly while the interrupt status is nonzero.
- R9: A nonzero write to 0x070 replaces the status byte with data bits 7:0. The byte drives dev_status_o and reads back at 0x070.
- R10: A zero write to 0x070 clears the status, the driver features, every queue's ready bit, size and addresses, and the interrupt status from the next cycle on. In that same cycle dev_reset_o is high for exactly one cycle.
- R11: Reads of 0x0B0, 0x0B4, 0x0B8 and 0x0BC return 0xFFFFFFFF for any shared-memory ID written at 0x0AC, because no region exists.
- R12: A write to 0x0C0 with bit 0 set clears the selected queue's ready bit, size and addresses only when driver feature bit RING_RESET_BIT (default 40) is set. Otherwise the write is ignored. A read of 0x0C0 returns zero.
- R13: Reads of write-only, unmapped or unaligned (address bits 1:0 nonzero) addresses return zero, and writes to the read-only addresses 0x000–0x010, 0x034 and 0x060 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| evt_i | input | 2 | Interrupt events: bit 0 used buffer, bit 1 config change |
| irq_o | output | 1 | Interrupt line |
| dev_reset_o | output | 1 | One-cycle device reset pulse |
| dev_status_o | output | 8 | Current device status byte |
| drv_feat_o | output | 64 | Negotiated driver features |
| q_ready_o | output | NUM_QUEUES | Per-queue ready bits |
| q_size_o | output | NUM_QUEUES*QSIZE_W | Per-queue sizes, queue 0 in the low bits |
| q_desc_o | output | NUM_QUEUES*64 | Per-queue descriptor area addresses |
| q_drv_o | output | NUM_QUEUES*64 | Per-queue driver area addresses |
| q_dev_o | output | NUM_QUEUES*64 | Per-queue device area addresses |

## Verification
The assertions check several rules on every cycle. An event survives a same-cycle acknowledge, and an acknowledge with no competing event clears its bit. A low-word feature write lands in the next cycle. A zero status write produces the reset pulse with the status cleared, the ready bits are all clear after a device reset, and a queue reset leaves the ready bits untouched while ring reset is not negotiated. Only the bench's scenarios can show the rest: queue banking across several selections, including an out-of-range one; the feature word selection; the constant shared-memory reads; and that writes to read-only addresses leave every visible register as it was. The bench shows these by comparing the read data and every output with a behavioural model on each cycle.

// File: rtl/pvd_pkg.sv
package pvd_pkg;
  localparam logic [11:0] OFF_MAGIC   = 12'h000;
  localparam logic [11:0] OFF_VER     = 12'h004;
  localparam logic [11:0] OFF_DEVID   = 12'h008;
  localparam logic [11:0] OFF_VENID   = 12'h00C;
  localparam logic [11:0] OFF_DFEAT   = 12'h010;
  localparam logic [11:0] OFF_DFSEL   = 12'h014;
  localparam logic [11:0] OFF_GFEAT   = 12'h020;
  localparam logic [11:0] OFF_GFSEL   = 12'h024;
  localparam logic [11:0] OFF_QSEL    = 12'h030;
  localparam logic [11:0] OFF_QMAX    = 12'h034;
  localparam logic [11:0] OFF_QNUM    = 12'h038;
  localparam logic [11:0] OFF_QRDY    = 12'h044;
  localparam logic [11:0] OFF_ISR     = 12'h060;
  localparam logic [11:0] OFF_IACK    = 12'h064;
  localparam logic [11:0] OFF_STAT    = 12'h070;
  localparam logic [11:0] OFF_DESC_LO = 12'h080;
  localparam logic [11:0] OFF_DESC_HI = 12'h084;
  localparam logic [11:0] OFF_DRV_LO  = 12'h090;
  localparam logic [11:0] OFF_DRV_HI  = 12'h094;
  localparam logic [11:0] OFF_DEV_LO  = 12'h0A0;
  localparam logic [11:0] OFF_DEV_HI  = 12'h0A4;
  localparam logic [11:0] OFF_SHM_LL  = 12'h0B0;
  localparam logic [11:0] OFF_SHM_LH  = 12'h0B4;
  localparam logic [11:0] OFF_SHM_BL  = 12'h0B8;
  localparam logic [11:0] OFF_SHM_BH  = 12'h0BC;
  localparam logic [11:0] OFF_QRST    = 12'h0C0;

  localparam logic [31:0] MAGIC_WORD  = 32'h7472_6976;
  localparam logic [31:0] VERSION_NUM = 32'd2;

  typedef enum logic [3:0] {
    QF_NONE, QF_SIZE, QF_READY,
    QF_DESC_LO, QF_DESC_HI, QF_DRV_LO, QF_DRV_HI, QF_DEV_LO, QF_DEV_HI
  } qfield_e;
endpackage

// File: rtl/pvd_irq.sv
module pvd_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] evt_i,
  input  logic       ack_we,
  input  logic [1:0] ack_mask,
  input  logic       clr,
  output logic [1:0] isr_o,
  output logic       irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   isr_o <= '0;
    else if (clr) isr_o <= '0;
    else          isr_o <= (isr_o & ~(ack_we ? ack_mask : 2'b00)) | evt_i;
  end

  assign irq_o = |isr_o;

  // R7
  evt_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[0] && !clr) |=> isr_o[0]);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ack_mask[0] && !evt_i[0]) |=> !isr_o[0]);
endmodule

// File: rtl/pvd_feat.sv
module pvd_feat #(
  parameter logic [63:0] DEV_FEATURES = 64'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dev_sel,
  input  logic [31:0] drv_sel,
  input  logic        drv_we,
  input  logic [31:0] wdata,
  input  logic        clr,
  output logic [31:0] dev_word_o,
  output logic [63:0] drv_feat_o
);
  always_comb begin
    if (dev_sel == 32'd0)      dev_word_o = DEV_FEATURES[31:0];
    else if (dev_sel == 32'd1) dev_word_o = DEV_FEATURES[63:32];
    else                       dev_word_o = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    drv_feat_o <= '0;
    else if (clr)  drv_feat_o <= '0;
    else if (drv_we && drv_sel == 32'd0) drv_feat_o[31:0]  <= wdata;
    else if (drv_we && drv_sel == 32'd1) drv_feat_o[63:32] <= wdata;
  end

  // R3
  low_word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_we && drv_sel == 32'd0 && !clr) |=> drv_feat_o[31:0] == $past(wdata));
endmodule

// File: rtl/pvd_queue_bank.sv
module pvd_queue_bank
  import pvd_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int QSIZE_W    = 16,
  localparam int IDX_W     = $clog2(NUM_QUEUES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              qidx_i,
  input  logic                          qvalid_i,
  input  qfield_e                       fld_i,
  input  logic [31:0]                   wdata,
  input  logic                          clr_all_i,
  input  logic                          clr_sel_i,
  output logic [NUM_QUEUES-1:0]         q_ready_o,
  output logic [NUM_QUEUES*QSIZE_W-1:0] q_size_o,
  output logic [NUM_QUEUES*64-1:0]      q_desc_o,
  output logic [NUM_QUEUES*64-1:0]      q_drv_o,
  output logic [NUM_QUEUES*64-1:0]      q_dev_o,
  output logic                          rd_ready_o
);
  for (genvar gi = 0; gi < NUM_QUEUES; gi++) begin : g_q
    logic               hit;
    logic               rdy;
    logic [QSIZE_W-1:0] sz;
    logic [63:0]        desc, drv, dev;

    assign hit = qvalid_i && (qidx_i == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy <= 1'b0; sz <= '0; desc <= '0; drv <= '0; dev <= '0;
      end else if (clr_all_i || (clr_sel_i && hit)) begin
        rdy <= 1'b0; sz <= '0; desc <= '0; drv <= '0; dev <= '0;
      end else if (hit) begin
        case (fld_i)
          QF_SIZE:    sz          <= wdata[QSIZE_W-1:0];
          QF_READY:   rdy         <= wdata[0];
          QF_DESC_LO: desc[31:0]  <= wdata;
          QF_DESC_HI: desc[63:32] <= wdata;
          QF_DRV_LO:  drv[31:0]   <= wdata;
          QF_DRV_HI:  drv[63:32]  <= wdata;
          QF_DEV_LO:  dev[31:0]   <= wdata;
          QF_DEV_HI:  dev[63:32]  <= wdata;
          default: ;
        endcase
      end
    end

    assign q_ready_o[gi]                   = rdy;
    assign q_size_o[gi*QSIZE_W +: QSIZE_W] = sz;
    assign q_desc_o[gi*64 +: 64]           = desc;
    assign q_drv_o[gi*64 +: 64]            = drv;
    assign q_dev_o[gi*64 +: 64]            = dev;
  end

  always_comb begin
    rd_ready_o = 1'b0;
    for (int i = 0; i < NUM_QUEUES; i++)
      if (qvalid_i && qidx_i == IDX_W'(i)) rd_ready_o = q_ready_o[i];
  end

  // R10
  clr_all_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (q_ready_o == '0));
endmodule

// File: rtl/pvd_regfile.sv
module pvd_regfile
  import pvd_pkg::*;
#(
  parameter int          NUM_QUEUES     = 4,
  parameter int          QSIZE_W        = 16,
  parameter int          QUEUE_MAX      = 256,
  parameter logic [31:0] DEVICE_ID      = 32'd1,
  parameter logic [31:0] VENDOR_ID      = 32'h0000_5A5A,
  parameter logic [63:0] DEV_FEATURES   = 64'h0000_0100_1234_5678,
  parameter int          RING_RESET_BIT = 40,
  localparam int         IDX_W          = $clog2(NUM_QUEUES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [11:0]                   bus_addr,
  input  logic                          bus_we,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [1:0]                    evt_i,
  output logic                          irq_o,
  output logic                          dev_reset_o,
  output logic [7:0]                    dev_status_o,
  output logic [63:0]                   drv_feat_o,
  output logic [NUM_QUEUES-1:0]         q_ready_o,
  output logic [NUM_QUEUES*QSIZE_W-1:0] q_size_o,
  output logic [NUM_QUEUES*64-1:0]      q_desc_o,
  output logic [NUM_QUEUES*64-1:0]      q_drv_o,
  output logic [NUM_QUEUES*64-1:0]      q_dev_o
);
  logic [11:0] off;
  logic        aligned;
  logic        wr;
  logic [31:0] dev_sel, drv_sel, qsel;
  logic        qvalid;
  logic        dev_clr, qrst_req, qrst_go;
  qfield_e     fld;
  logic [31:0] dev_word;
  logic [1:0]  isr;
  logic        rd_ready;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign off     = aligned ? bus_addr : 12'hFFF;
  assign wr      = bus_we && aligned;
  assign qvalid  = (qsel < 32'(NUM_QUEUES));

  assign dev_clr  = wr && off == OFF_STAT && bus_wdata == 32'd0;
  assign qrst_req = wr && off == OFF_QRST && bus_wdata[0];
  assign qrst_go  = qrst_req && drv_feat_o[RING_RESET_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_sel <= '0; drv_sel <= '0; qsel <= '0;
      dev_status_o <= '0; dev_reset_o <= 1'b0;
    end else begin
      dev_reset_o <= dev_clr;
      if (wr && off == OFF_DFSEL) dev_sel <= bus_wdata;
      if (wr && off == OFF_GFSEL) drv_sel <= bus_wdata;
      if (wr && off == OFF_QSEL)  qsel    <= bus_wdata;
      if (dev_clr) dev_status_o <= '0;
      else if (wr && off == OFF_STAT) dev_status_o <= bus_wdata[7:0];
    end
  end

  always_comb begin
    fld = QF_NONE;
    if (wr) begin
      case (off)
        OFF_QNUM:    fld = QF_SIZE;
        OFF_QRDY:    fld = QF_READY;
        OFF_DESC_LO: fld = QF_DESC_LO;
        OFF_DESC_HI: fld = QF_DESC_HI;
        OFF_DRV_LO:  fld = QF_DRV_LO;
        OFF_DRV_HI:  fld = QF_DRV_HI;
        OFF_DEV_LO:  fld = QF_DEV_LO;
        OFF_DEV_HI:  fld = QF_DEV_HI;
        default:     fld = QF_NONE;
      endcase
    end
  end

  pvd_feat #(.DEV_FEATURES(DEV_FEATURES)) u_feat (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .drv_sel(drv_sel),
    .drv_we(wr && off == OFF_GFEAT), .wdata(bus_wdata), .clr(dev_clr),
    .dev_word_o(dev_word), .drv_feat_o(drv_feat_o)
  );

  pvd_queue_bank #(.NUM_QUEUES(NUM_QUEUES), .QSIZE_W(QSIZE_W)) u_qbank (
    .clk(clk), .rst_n(rst_n), .qidx_i(qsel[IDX_W-1:0]), .qvalid_i(qvalid),
    .fld_i(fld), .wdata(bus_wdata), .clr_all_i(dev_clr), .clr_sel_i(qrst_go),
    .q_ready_o(q_ready_o), .q_size_o(q_size_o), .q_desc_o(q_desc_o),
    .q_drv_o(q_drv_o), .q_dev_o(q_dev_o), .rd_ready_o(rd_ready)
  );

  pvd_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .ack_we(wr && off == OFF_IACK), .ack_mask(bus_wdata[1:0]),
    .clr(dev_clr), .isr_o(isr), .irq_o(irq_o)
  );

  always_comb begin
    case (off)
      OFF_MAGIC: bus_rdata = MAGIC_WORD;
      OFF_VER:   bus_rdata = VERSION_NUM;
      OFF_DEVID: bus_rdata = DEVICE_ID;
      OFF_VENID: bus_rdata = VENDOR_ID;
      OFF_DFEAT: bus_rdata = dev_word;
      OFF_QMAX:  bus_rdata = qvalid ? 32'(QUEUE_MAX) : 32'd0;
      OFF_QRDY:  bus_rdata = {31'd0, rd_ready};
      OFF_ISR:   bus_rdata = {30'd0, isr};
      OFF_STAT:  bus_rdata = {24'd0, dev_status_o};
      OFF_SHM_LL, OFF_SHM_LH, OFF_SHM_BL, OFF_SHM_BH: bus_rdata = 32'hFFFF_FFFF;
      default:   bus_rdata = 32'd0;
    endcase
  end

  // R10
  zero_status_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clr |=> (dev_reset_o && dev_status_o == 8'd0 && drv_feat_o == 64'd0));

  // R12
  qreset_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qrst_req && !drv_feat_o[RING_RESET_BIT]) |=> $stable(q_ready_o));
endmodule

// File: tb/sim_pvd_regfile.sv
module sim_pvd_regfile;
  localparam int          NQ   = 4;
  localparam int          QW   = 16;
  localparam int          QMAX = 256;
  localparam logic [31:0] DID  = 32'd1;
  localparam logic [31:0] VID  = 32'h0000_5A5A;
  localparam logic [63:0] DFT  = 64'h0000_0100_1234_5678;

  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [1:0] evt = '0;
  logic irq_o, dev_reset_o;
  logic [7:0] dev_status_o;
  logic [63:0] drv_feat_o;
  logic [NQ-1:0] q_ready_o;
  logic [NQ*QW-1:0] q_size_o;
  logic [NQ*64-1:0] q_desc_o, q_drv_o, q_dev_o;

  always #5 clk = ~clk;

  pvd_regfile #(.NUM_QUEUES(NQ), .QSIZE_W(QW), .QUEUE_MAX(QMAX), .DEVICE_ID(DID),
                .VENDOR_ID(VID), .DEV_FEATURES(DFT), .RING_RESET_BIT(40)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt), .irq_o(irq_o),
    .dev_reset_o(dev_reset_o), .dev_status_o(dev_status_o), .drv_feat_o(drv_feat_o),
    .q_ready_o(q_ready_o), .q_size_o(q_size_o), .q_desc_o(q_desc_o),
    .q_drv_o(q_drv_o), .q_dev_o(q_dev_o)
  );

  int ncmp = 0, nbad = 0;

  // behavioural reference state
  logic [31:0] m_fsel = 0, m_dsel = 0, m_qsel = 0;
  logic [63:0] m_drv = 0;
  logic        m_rdy [NQ];
  logic [15:0] m_sz  [NQ];
  logic [63:0] m_desc[NQ], m_dr[NQ], m_dv[NQ];
  logic [1:0]  m_isr = 0;
  logic [7:0]  m_stat = 0;
  logic        m_rst = 0;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic string tag(logic [11:0] a);
    if (a[1:0] != 0) return "R13";
    case (a)
      12'h000, 12'h004, 12'h008, 12'h00C: return "R1";
      12'h010: return "R2";
      12'h034: return "R4";
      12'h044: return "R5";
      12'h060: return "R7";
      12'h070: return "R9";
      12'h0B0, 12'h0B4, 12'h0B8, 12'h0BC: return "R11";
      12'h0C0: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [31:0] mread(logic [11:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      12'h000: return 32'h7472_6976;
      12'h004: return 2;
      12'h008: return DID;
      12'h00C: return VID;
      12'h010: return (m_fsel == 0) ? DFT[31:0] : (m_fsel == 1) ? DFT[63:32] : 0;
      12'h034: return (m_qsel < NQ) ? QMAX : 0;
      12'h044: return (m_qsel < NQ) ? {31'd0, m_rdy[m_qsel[1:0]]} : 0;
      12'h060: return {30'd0, m_isr};
      12'h070: return {24'd0, m_stat};
      12'h0B0, 12'h0B4, 12'h0B8, 12'h0BC: return 32'hFFFF_FFFF;
      default: return 0;
    endcase
  endfunction

  task automatic clear_q(int i);
    m_rdy[i] = 0; m_sz[i] = 0; m_desc[i] = 0; m_dr[i] = 0; m_dv[i] = 0;
  endtask

  task automatic mupd(logic [11:0] a, logic w, logic [31:0] d, logic [1:0] e);
    logic clr = 0;
    logic [1:0] ack = 0;
    int q = int'(m_qsel[1:0]);
    logic qok = (m_qsel < NQ);
    if (w && a[1:0] == 0) begin
      case (a)
        12'h014: m_fsel = d;
        12'h024: m_dsel = d;
        12'h020: if (m_dsel == 0) m_drv[31:0] = d; else if (m_dsel == 1) m_drv[63:32] = d;
        12'h030: m_qsel = d;
        12'h038: if (qok) m_sz[q] = d[15:0];
        12'h044: if (qok) m_rdy[q] = d[0];
        12'h080: if (qok) m_desc[q][31:0] = d;
        12'h084: if (qok) m_desc[q][63:32] = d;
        12'h090: if (qok) m_dr[q][31:0] = d;
        12'h094: if (qok) m_dr[q][63:32] = d;
        12'h0A0: if (qok) m_dv[q][31:0] = d;
        12'h0A4: if (qok) m_dv[q][63:32] = d;
        12'h064: ack = d[1:0];
        12'h070: if (d == 0) clr = 1; else m_stat = d[7:0];
        12'h0C0: if (d[0] && m_drv[40] && qok) clear_q(q);
        default: ;
      endcase
    end
    m_isr = clr ? 2'b00 : ((m_isr & ~ack) | e);
    if (clr) begin
      m_stat = 0; m_drv = 0;
      for (int i = 0; i < NQ; i++) clear_q(i);
    end
    m_rst = clr;
  endtask

  task automatic compare_all(logic [11:0] a);
    chk(tag(a), 64'(bus_rdata), 64'(mread(a)));
    chk("R8", 64'(irq_o), 64'(m_isr != 0));
    chk("R10", 64'(dev_reset_o), 64'(m_rst));
    chk("R9", 64'(dev_status_o), 64'(m_stat));
    chk("R3", drv_feat_o, m_drv);
    for (int i = 0; i < NQ; i++) begin
      chk("R5", 64'(q_ready_o[i]), 64'(m_rdy[i]));
      chk("R6", 64'(q_size_o[i*QW +: QW]), 64'(m_sz[i]));
      chk("R6", q_desc_o[i*64 +: 64], m_desc[i]);
      chk("R6", q_drv_o[i*64 +: 64], m_dr[i]);
      chk("R6", q_dev_o[i*64 +: 64], m_dv[i]);
    end
  endtask

  // one bus cycle, called just after a falling edge
  task automatic step(logic [11:0] a, logic w, logic [31:0] d, logic [1:0] e = 2'b00);
    bus_addr = a; bus_we = w; bus_wdata = d; evt = e;
    #1 compare_all(a);
    @(posedge clk);
    mupd(a, w, d, e);
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d); step(a, 1'b1, d); endtask
  task automatic rd(logic [11:0] a); step(a, 1'b0, 32'd0); endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NQ; i++) clear_q(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state and identification (R1, R13)
    rd(12'h000); rd(12'h004); rd(12'h008); rd(12'h00C);
    rd(12'h060); rd(12'h070); rd(12'h014); rd(12'h0F0); rd(12'h002);
    // R2 device feature words
    rd(12'h010); wr(12'h014, 1); rd(12'h010); wr(12'h014, 2); rd(12'h010);
    // R12 queue reset without negotiation is ignored
    wr(12'h030, 0); wr(12'h044, 1); wr(12'h0C0, 1); rd(12'h044); rd(12'h0C0);
    // R3 driver features, including an ignored select
    wr(12'h024, 0); wr(12'h020, 32'hCAFE_0001);
    wr(12'h024, 1); wr(12'h020, 32'h0000_0100);
    wr(12'h024, 5); wr(12'h020, 32'hDEAD_BEEF);
    // R4/R6 queue programming on queues 0 and 2
    wr(12'h030, 0); wr(12'h038, 128);
    wr(12'h080, 32'h1000_0000); wr(12'h084, 32'h1);
    wr(12'h090, 32'h2000_0000); wr(12'h094, 32'h2);
    wr(12'h0A0, 32'h3000_0000); wr(12'h0A4, 32'h3);
    wr(12'h030, 2); rd(12'h034); wr(12'h038, 64); wr(12'h044, 32'h3);
    wr(12'h084, 32'hABCD); rd(12'h044);
    // R4/R6 out-of-range selection
    wr(12'h030, 7); rd(12'h034); wr(12'h038, 9); wr(12'h044, 1); rd(12'h044);
    wr(12'h080, 32'h5555);
    // R5 per-queue readback
    wr(12'h030, 1); rd(12'h044); wr(12'h030, 0); rd(12'h044);
    wr(12'h044, 32'h2); rd(12'h044); wr(12'h044, 1);
    // R7/R8 events and acknowledges
    step(12'h060, 0, 0, 2'b01); rd(12'h060);
    step(12'h060, 0, 0, 2'b10); rd(12'h060);
    wr(12'h064, 32'h1); rd(12'h060);
    step(12'h064, 1, 32'h2, 2'b10); rd(12'h060);
    wr(12'h064, 32'h3); rd(12'h060);
    // R13 writes to read-only addresses
    wr(12'h000, 32'h0); wr(12'h034, 32'h7); step(12'h060, 0, 0, 2'b01);
    wr(12'h060, 32'h0); rd(12'h060); rd(12'h000); rd(12'h034);
    // R9 status
    wr(12'h070, 32'h0F); rd(12'h070); wr(12'h070, 32'h8B); rd(12'h070);
    // R11 shared memory reads
    wr(12'h0AC, 3); rd(12'h0B0); rd(12'h0B4); rd(12'h0B8); rd(12'h0BC);
    // R12 queue reset with ring reset negotiated: queue 0 only
    wr(12'h030, 0); wr(12'h0C0, 1); rd(12'h044);
    wr(12'h030, 2); rd(12'h044);
    // R10 device reset
    step(12'h060, 0, 0, 2'b11);
    wr(12'h070, 32'h0); rd(12'h070); rd(12'h060); rd(12'h044);
    rd(12'h000); rd(12'h000);
    finish_run();
  end
endmodule